// File: doc/BRIEF.md
# UART Channel Command Decoder

This block is the command path of one UART channel. Each write carries an 8-bit command word. The low four bits switch the transmitter and the receiver on and off. The high four bits select a one-shot action: return the mode-register pointer to its first register, reset the receiver, reset the transmitter, clear the error status, or clear the break-change interrupt. The block holds the enable flags and the mode-register pointer. It qualifies the transmitter-ready and transmitter-empty indications. It drives one single-cycle strobe per action toward the serial datapath, which sits outside this block.

The host writes commands over a valid/ready port. `cmd_ready` is always high, so there is never back-pressure: every cycle with `cmd_valid` high is one accepted write. Reset and clear actions must be spaced by a minimum number of rising edges of a slow reference clock, `x1_clk`, which is asynchronous to `clk`. The block synchronises that clock and counts its edges. An action that comes too early is dropped and recorded in a sticky violation flag. The transmitter shifter and FIFO appear only as the status inputs `tx_busy`, `tx_fifo_empty` and `tx_fifo_space`.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: `cmd_ready` is 1 at all times. A write is accepted on every rising edge of `clk` where `cmd_valid` is 1. Its effects are visible on registered outputs right after that edge.
- R2: After reset, `tx_en` and `rx_en` are 0 and `mr_ptr` is 0 (the first mode register). `tx_rdy`, `tx_emt`, `space_viol`, `proto_err` and every action strobe are 0.
- R3: The low bits act as follows: bit 3 clears `tx_en`, bit 2 sets `tx_en`, bit 1 clears `rx_en` and bit 0 sets `rx_en`. If bits 3 and 2 are both set, `tx_en` is unchanged, and the same holds for `rx_en` with bits 1 and 0. In either case `proto_err` is high for exactly one cycle.
- R4: Bits 7:4 select an action. 0001 pulses `mr_ptr_rst_p`, 0010 pulses `rx_rst_p`, 0011 pulses `tx_rst_p`, 0100 pulses `err_clr_p` and 0101 pulses `brk_clr_p`. Each strobe lasts one cycle. Codes 0000 and 0110 to 1111 produce no strobe and do not restart the spacing window.
- R5: Each cycle with `mr_adv` high advances `mr_ptr` by one, saturating at NUM_MR-1. Code 0001 returns it to 0 and takes priority over `mr_adv`.
- R6: Code 0010 clears `rx_en` and code 0011 clears `tx_en`. Each reset also ends any transmit drain, and it overrides an enable bit written in the same word.
- R7: A transmitter disable given while `tx_busy` is 1 or `tx_fifo_empty` is 0 keeps `tx_active` at 1. `tx_active` falls one cycle after both inputs show idle. `tx_rdy` and `tx_emt` drop at once.
- R8: `tx_rdy` is 1 exactly when `tx_en` and `tx_fifo_space` are both 1. `tx_emt` is 1 exactly when `tx_en` is 1, `tx_busy` is 0 and `tx_fifo_empty` is 1.
- R9: A receiver disable clears `rx_en` right after the write edge. `rx_active` is 1 when `rx_en` is 1 or `multidrop_en` is 1.
- R10: An accepted receiver enable pulses `rx_search_p` for one cycle, unless `wakeup_mode` is 1 or the same word resets the receiver.
- R11: After an action executes, the next action is dropped until SPACING (default 3) synchronised rising edges of `x1_clk` have been counted. A dropped action sets `space_viol`. The low bits of that write still take effect.
- R12: `space_viol` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x1_clk | input | 1 | Reference clock, asynchronous, sampled |
| cmd_valid | input | 1 | Command write valid |
| cmd_ready | output | 1 | Always 1 |
| cmd_data | input | 8 | Command word |
| mr_adv | input | 1 | Mode-register access, advances pointer |
| multidrop_en | input | 1 | Multi-drop mode keeps receiver running |
| wakeup_mode | input | 1 | Wake-up mode, suppresses start-bit re-arm |
| tx_busy | input | 1 | Transmit shifter holds a character |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_space | input | 1 | Transmit FIFO can take a character |
| tx_en | output | 1 | Transmitter enable flag |
| tx_active | output | 1 | Transmitter enabled or draining |
| tx_rdy | output | 1 | Qualified transmitter ready |
| tx_emt | output | 1 | Qualified transmitter empty |
| rx_en | output | 1 | Receiver enable flag |
| rx_active | output | 1 | Receiver operating |
| rx_search_p | output | 1 | Re-arm start-bit search strobe |
| mr_ptr | output | clog2(NUM_MR) (2) | Mode-register pointer |
| mr_ptr_rst_p | output | 1 | Pointer reset strobe |
| rx_rst_p | output | 1 | Receiver reset / FIFO flush strobe |
| tx_rst_p | output | 1 | Transmitter reset strobe |
| err_clr_p | output | 1 | Error-status clear strobe |
| brk_clr_p | output | 1 | Break-change interrupt clear strobe |
| proto_err | output | 1 | Conflicting-pair strobe |
| space_viol | output | 1 | Sticky spacing violation |

## Verification
Most wrong internal states show on the ports in the cycle after the write edge. A lost or stuck enable flag shows on `tx_en` or `rx_en` and, through them, on `tx_rdy`, `tx_emt` and `rx_active`. A wrong decode shows as a missing or extra strobe. The spacing counter is harder to see. A wrong count only shows when an action arrives near the window boundary: it is then dropped when it should execute, or executes when it should be dropped. The bench therefore probes that boundary one edge short of the window and again exactly at it. A stuck drain state only shows once the shifter goes idle, when `tx_active` fails to fall one cycle later.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_MR_PTR  = 4'd1,
    OP_RX_RST  = 4'd2,
    OP_TX_RST  = 4'd3,
    OP_ERR_CLR = 4'd4,
    OP_BRK_CLR = 4'd5
  } misc_op_e;

  localparam int unsigned BIT_TX_OFF = 3;
  localparam int unsigned BIT_TX_ON  = 2;
  localparam int unsigned BIT_RX_OFF = 1;
  localparam int unsigned BIT_RX_ON  = 0;

  function automatic logic op_counted(input logic [3:0] code);
    return (code >= OP_MR_PTR) && (code <= OP_BRK_CLR);
  endfunction
endpackage

// File: rtl/ucc_edge_sync.sv
module ucc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_in;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ucc_gap_gate.sv
module ucc_gap_gate #(
  parameter int unsigned SPACING = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic grant,
  output logic deny
);
  localparam int unsigned CW = $clog2(SPACING + 1);
  logic [CW-1:0] cnt_q;
  logic          open_w;

  assign open_w = (cnt_q >= CW'(SPACING));
  assign grant  = req & open_w;
  assign deny   = req & ~open_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= CW'(SPACING);
    else if (grant)          cnt_q <= '0;
    else if (tick && !open_w) cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/ucc_en_pair.sv
module ucc_en_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic on_bit,
  input  logic off_bit,
  input  logic force_off,
  output logic en,
  output logic conflict,
  output logic set_evt,
  output logic clr_evt
);
  assign conflict = wr & on_bit & off_bit;
  assign set_evt  = wr & on_bit & ~off_bit & ~force_off;
  assign clr_evt  = wr & off_bit & ~on_bit & ~force_off;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       en <= 1'b0;
    else if (force_off) en <= 1'b0;
    else if (set_evt)   en <= 1'b1;
    else if (clr_evt)   en <= 1'b0;
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SPACING     = 3,
  parameter int unsigned NUM_MR      = 3,
  localparam int unsigned PW         = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x1_clk,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [7:0]    cmd_data,
  input  logic          mr_adv,
  input  logic          multidrop_en,
  input  logic          wakeup_mode,
  input  logic          tx_busy,
  input  logic          tx_fifo_empty,
  input  logic          tx_fifo_space,
  output logic          tx_en,
  output logic          tx_active,
  output logic          tx_rdy,
  output logic          tx_emt,
  output logic          rx_en,
  output logic          rx_active,
  output logic          rx_search_p,
  output logic [PW-1:0] mr_ptr,
  output logic          mr_ptr_rst_p,
  output logic          rx_rst_p,
  output logic          tx_rst_p,
  output logic          err_clr_p,
  output logic          brk_clr_p,
  output logic          proto_err,
  output logic          space_viol
);
  logic       x1_rise, grant, deny;
  logic [3:0] op;
  logic       tx_force, rx_force;
  logic       tx_conf, rx_conf, tx_set, tx_clr, rx_set, rx_clr;
  logic       tx_drain_q, tx_idle;

  assign cmd_ready = 1'b1;
  assign op        = cmd_data[7:4];

  ucc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(x1_clk), .rise(x1_rise)
  );

  ucc_gap_gate #(.SPACING(SPACING)) u_gate (
    .clk(clk), .rst_n(rst_n), .tick(x1_rise),
    .req(cmd_valid & op_counted(op)), .grant(grant), .deny(deny)
  );

  assign tx_force = grant & (op == OP_TX_RST);
  assign rx_force = grant & (op == OP_RX_RST);

  ucc_en_pair u_tx (
    .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
    .on_bit(cmd_data[BIT_TX_ON]), .off_bit(cmd_data[BIT_TX_OFF]),
    .force_off(tx_force), .en(tx_en), .conflict(tx_conf),
    .set_evt(tx_set), .clr_evt(tx_clr)
  );

  ucc_en_pair u_rx (
    .clk(clk), .rst_n(rst_n), .wr(cmd_valid),
    .on_bit(cmd_data[BIT_RX_ON]), .off_bit(cmd_data[BIT_RX_OFF]),
    .force_off(rx_force), .en(rx_en), .conflict(rx_conf),
    .set_evt(rx_set), .clr_evt(rx_clr)
  );

  // action strobes, conflict and violation flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mr_ptr_rst_p <= 1'b0;
      rx_rst_p     <= 1'b0;
      tx_rst_p     <= 1'b0;
      err_clr_p    <= 1'b0;
      brk_clr_p    <= 1'b0;
      proto_err    <= 1'b0;
      space_viol   <= 1'b0;
      rx_search_p  <= 1'b0;
    end else begin
      mr_ptr_rst_p <= grant & (op == OP_MR_PTR);
      rx_rst_p     <= rx_force;
      tx_rst_p     <= tx_force;
      err_clr_p    <= grant & (op == OP_ERR_CLR);
      brk_clr_p    <= grant & (op == OP_BRK_CLR);
      proto_err    <= tx_conf | rx_conf;
      space_viol   <= space_viol | deny;
      rx_search_p  <= rx_set & ~wakeup_mode;
    end

  // mode-register pointer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   mr_ptr <= '0;
    else if (grant && op == OP_MR_PTR)            mr_ptr <= '0;
    else if (mr_adv && mr_ptr != PW'(NUM_MR - 1)) mr_ptr <= mr_ptr + 1'b1;

  // transmitter drain after disable
  assign tx_idle = ~tx_busy & tx_fifo_empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                        tx_drain_q <= 1'b0;
    else if (tx_force || tx_set)                       tx_drain_q <= 1'b0;
    else if (tx_clr && (tx_en || tx_drain_q) && !tx_idle) tx_drain_q <= 1'b1;
    else if (tx_idle)                                  tx_drain_q <= 1'b0;

  assign tx_active = tx_en | tx_drain_q;
  assign tx_rdy    = tx_en & tx_fifo_space;
  assign tx_emt    = tx_en & tx_idle;
  assign rx_active = rx_en | multidrop_en;
endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       tx_busy,
  input logic       tx_fifo_empty,
  input logic       tx_en,
  input logic       tx_active,
  input logic       rx_en,
  input logic       rx_search_p,
  input logic       mr_ptr_rst_p,
  input logic       rx_rst_p,
  input logic       tx_rst_p,
  input logic       err_clr_p,
  input logic       brk_clr_p,
  input logic       proto_err,
  input logic       space_viol
);
  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready);

  a_r3_conflict_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[3] && cmd_data[2]) |=> proto_err);

  a_r3_tx_conflict_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[3] && cmd_data[2] && cmd_data[7:4] != 4'd3)
      |=> (tx_en == $past(tx_en)));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mr_ptr_rst_p, rx_rst_p, tx_rst_p, err_clr_p, brk_clr_p}));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_p |=> !rx_rst_p);

  a_r6_rx_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_p |-> !rx_en);

  a_r6_tx_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_p |-> !tx_active);

  a_r7_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_en && (tx_busy || !tx_fifo_empty)
      && !(cmd_valid && cmd_data[7:4] == 4'd3)) |=> tx_active);

  a_r10_search_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_search_p |-> rx_en);

  a_r12_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    space_viol |=> space_viol);
endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .tx_busy(tx_busy), .tx_fifo_empty(tx_fifo_empty),
  .tx_en(tx_en), .tx_active(tx_active), .rx_en(rx_en),
  .rx_search_p(rx_search_p), .mr_ptr_rst_p(mr_ptr_rst_p),
  .rx_rst_p(rx_rst_p), .tx_rst_p(tx_rst_p), .err_clr_p(err_clr_p),
  .brk_clr_p(brk_clr_p), .proto_err(proto_err), .space_viol(space_viol)
);

// File: tb/sim_uart_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_uart_cmd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x1_clk = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       mr_adv = 1'b0, multidrop_en = 1'b0, wakeup_mode = 1'b0;
  logic       tx_busy = 1'b0, tx_fifo_empty = 1'b1, tx_fifo_space = 1'b1;
  logic       cmd_ready, tx_en, tx_active, tx_rdy, tx_emt, rx_en, rx_active;
  logic       rx_search_p, mr_ptr_rst_p, rx_rst_p, tx_rst_p, err_clr_p;
  logic       brk_clr_p, proto_err, space_viol;
  logic [1:0] mr_ptr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  uart_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .x1_clk(x1_clk), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .mr_adv(mr_adv),
    .multidrop_en(multidrop_en), .wakeup_mode(wakeup_mode),
    .tx_busy(tx_busy), .tx_fifo_empty(tx_fifo_empty),
    .tx_fifo_space(tx_fifo_space), .tx_en(tx_en), .tx_active(tx_active),
    .tx_rdy(tx_rdy), .tx_emt(tx_emt), .rx_en(rx_en), .rx_active(rx_active),
    .rx_search_p(rx_search_p), .mr_ptr(mr_ptr), .mr_ptr_rst_p(mr_ptr_rst_p),
    .rx_rst_p(rx_rst_p), .tx_rst_p(tx_rst_p), .err_clr_p(err_clr_p),
    .brk_clr_p(brk_clr_p), .proto_err(proto_err), .space_viol(space_viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one accepted write; returns at the negedge after the write edge
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
  endtask

  task automatic x1_edges(input int n);
    for (int i = 0; i < n; i++) begin
      x1_clk = 1'b1;
      repeat (3) @(negedge clk);
      x1_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  function automatic int strobes();
    return int'(mr_ptr_rst_p) + int'(rx_rst_p) + int'(tx_rst_p)
         + int'(err_clr_p) + int'(brk_clr_p);
  endfunction

  task automatic t_reset();
    chk("R2 tx_en", tx_en, 0);
    chk("R2 rx_en", rx_en, 0);
    chk("R2 mr_ptr", mr_ptr, 0);
    chk("R2 tx_rdy", tx_rdy, 0);
    chk("R2 tx_emt", tx_emt, 0);
    chk("R2 space_viol", space_viol, 0);
    chk("R2 strobes", strobes() + int'(proto_err), 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_lower();
    wr(8'h04);
    chk("R3 tx enable", tx_en, 1);
    chk("R8 tx_rdy", tx_rdy, 1);
    chk("R8 tx_emt", tx_emt, 1);
    tx_fifo_space = 1'b0;
    #1 chk("R8 tx_rdy no space", tx_rdy, 0);
    tx_fifo_space = 1'b1;
    wr(8'h01);
    chk("R10 search pulse", rx_search_p, 1);
    chk("R3 rx enable", rx_en, 1);
    @(negedge clk);
    chk("R10 search one cycle", rx_search_p, 0);
    wr(8'h0C);
    chk("R3 tx conflict keeps", tx_en, 1);
    chk("R3 proto_err", proto_err, 1);
    @(negedge clk);
    chk("R3 proto_err one cycle", proto_err, 0);
    wr(8'h02);
    chk("R9 rx disable", rx_en, 0);
    chk("R9 rx_active off", rx_active, 0);
    multidrop_en = 1'b1;
    #1 chk("R9 multidrop active", rx_active, 1);
    multidrop_en = 1'b0;
    wr(8'h03);
    chk("R3 rx conflict keeps", rx_en, 0);
    wakeup_mode = 1'b1;
    wr(8'h01);
    chk("R10 no search in wakeup", rx_search_p, 0);
    chk("R3 rx enable wakeup", rx_en, 1);
    wakeup_mode = 1'b0;
  endtask

  task automatic t_upper();
    wr(8'h40);
    chk("R4 err_clr", err_clr_p, 1);
    chk("R4 only one strobe", strobes(), 1);
    @(negedge clk);
    chk("R4 strobe one cycle", err_clr_p, 0);
    x1_edges(3);
    wr(8'h50);
    chk("R4 brk_clr", brk_clr_p, 1);
    x1_edges(3);
    wr(8'h00);
    chk("R4 nop no strobe", strobes(), 0);
    wr(8'h70);
    chk("R4 reserved no strobe", strobes(), 0);
    wr(8'h40);
    chk("R4 reserved no restart", err_clr_p, 1);
    chk("R11 no violation", space_viol, 0);
  endtask

  task automatic t_ptr();
    repeat (4) begin
      @(negedge clk) mr_adv = 1'b1;
    end
    @(negedge clk) mr_adv = 1'b0;
    chk("R5 pointer saturates", mr_ptr, 2);
    x1_edges(3);
    @(negedge clk);
    mr_adv = 1'b1;
    wr(8'h10);
    mr_adv = 1'b0;
    chk("R5 pointer reset wins", mr_ptr, 0);
    chk("R4 mr strobe", mr_ptr_rst_p, 1);
  endtask

  task automatic t_resets();
    x1_edges(3);
    wr(8'h21);
    chk("R6 rx reset beats enable", rx_en, 0);
    chk("R4 rx_rst strobe", rx_rst_p, 1);
    chk("R10 no search on reset", rx_search_p, 0);
    x1_edges(3);
    wr(8'h34);
    chk("R6 tx reset beats enable", tx_en, 0);
    chk("R4 tx_rst strobe", tx_rst_p, 1);
  endtask

  task automatic t_drain();
    wr(8'h04);
    tx_busy = 1'b1;
    wr(8'h08);
    chk("R7 tx_en off", tx_en, 0);
    chk("R7 still active", tx_active, 1);
    chk("R7 tx_rdy drops", tx_rdy, 0);
    chk("R7 tx_emt drops", tx_emt, 0);
    tx_busy = 1'b0;
    tx_fifo_empty = 1'b0;
    @(negedge clk);
    chk("R7 fifo pending active", tx_active, 1);
    tx_fifo_empty = 1'b1;
    @(negedge clk);
    chk("R7 falls after idle", tx_active, 0);
  endtask

  task automatic t_space();
    x1_edges(3);
    wr(8'h40);
    chk("R11 first executes", err_clr_p, 1);
    x1_edges(2);
    wr(8'h44);
    chk("R11 early dropped", err_clr_p, 0);
    chk("R11 violation set", space_viol, 1);
    chk("R11 low bits still act", tx_en, 1);
    x1_edges(1);
    wr(8'h50);
    chk("R11 executes at window", brk_clr_p, 1);
    chk("R12 violation sticky", space_viol, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lower();
    t_upper();
    t_ptr();
    t_resets();
    t_drain();
    t_space();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule